// File: doc/BRIEF.md
# Paged Address Memory Mapper

This block widens a 16-bit processor address into a physical address through a small page table. The top four address bits pick one of sixteen entries. When mapping is switched on, that entry takes the place of those four bits. The low twelve bits pass through unchanged, so each page is 4 KB. With full 12-bit entries the physical address is 24 bits wide.

While mapping is switched off, the block acts as an identity map. The four page-select bits pass through as they are, and every physical bit above them reads zero. Translation is purely combinational, so a downstream address decoder sees the physical address in the same cycle as the processor address.

Software sets the block up through a register port with two write strobes. One strobe loads a table entry: the entry index comes from a small register-address field and the value from the data bus. The other strobe loads the control word, whose only meaningful bit is the enable. A parameter limits how many bits of each entry are stored. Setting it to 8 gives a 20-bit physical address.

Top module: `pagemap_top`

## Requirements
- R1: A synchronous active-low reset clears the enable, so the block comes out of reset in identity mode. A control write held during reset has no effect.
- R2: While disabled, the physical address equals the 16-bit processor address, zero-extended to the physical width.
- R3: While enabled, physical bits [11:0] equal processor bits [11:0]. The bits above them equal the table entry selected by processor bits [15:12].
- R4: When `tbl_wr` is high at a rising clock edge, the entry at index `reg_idx` is loaded with the low entry-width bits of `reg_wdata`. The new value shows in the translation only after that edge, not in the cycle the strobe is driven.
- R5: A table write leaves the enable unchanged, and a control write leaves every table entry unchanged.
- R6: When `ctl_wr` is high at a rising clock edge, the enable takes `reg_wdata[0]`. Bits [11:1] of the data are ignored.
- R7: With the entry width set to 8, the physical address is 20 bits wide. Data bits [11:8] of a table write are discarded and never reach the output.
- R8: A change on `cpu_addr` shows on `phys_addr` within the same cycle, with no clock edge needed.
- R9: Rewriting one entry while enabled changes the translation of that page only. All other pages keep their mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Processor address to translate |
| reg_idx | input | 4 | Table index for an entry write |
| reg_wdata | input | 12 | Write data for the table or the control word |
| tbl_wr | input | 1 | Strobe that writes a table entry |
| ctl_wr | input | 1 | Strobe that writes the control word |
| phys_addr | output | 24 | Translated physical address (12 + entry width) |

## Verification
The assertions check several things on every cycle: the offset pass-through, the zeroed upper bits in identity mode, that a table write lands in the indexed entry, that a control write loads the enable, that the enable holds with no control write, and that the enable is cleared after reset. Some behaviours only the directed scenarios can show. These are the translation of each page after programming, the same-cycle response to address changes, the one-cycle lag before a new entry is visible, that rewriting one page leaves the others alone, and the truncation in the narrow-entry variant.

// File: rtl/pagemap_pkg.sv
// Package: pagemap_pkg
// Holds the default geometry shared by the mapper modules and the bench.
// Assumes the entry width is at least the index width and no wider than the data bus.
package pagemap_pkg;
    localparam int unsigned PM_ADDR_W = 16;
    localparam int unsigned PM_IDX_W  = 4;
    localparam int unsigned PM_BUS_W  = 12;
    localparam int unsigned PM_USE_W  = 12;
endpackage

// File: rtl/pagemap_table.sv
// Module: pagemap_table
// Page table storage: one write port from the register side and one
// combinational read port for translation. It has no reset; software must
// load the entries before it enables mapping.
module pagemap_table #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned USE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [USE_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [USE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [USE_W-1:0] mem_q [DEPTH];

    // Load the addressed entry on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    // Read the entry selected by the page bits without a clock.
    assign rdata = mem_q[ridx];

    // The written value must be present in the indexed entry after the edge.
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/pagemap_ctrl.sv
// Module: pagemap_ctrl
// Control word register. Only the enable bit is kept, so the caller passes
// bit 0 of the data bus. Reset takes priority over a write in the same cycle.
module pagemap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wbit,
    output logic en
);
    logic en_q;
    logic rst_seen_q;

    // Hold the enable; clear it on reset, load it on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (we) begin
            en_q <= wbit;
        end
    end

    // Remember that the previous edge saw reset, for the reset check below.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    assign en = en_q;

    // After a reset edge the enable must read low.
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clears_R1: assert (!en_q);
        end
    end

    assert_ctrl_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (en_q == $past(wbit)));

    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en_q));
endmodule

// File: rtl/pagemap_xlate.sv
// Module: pagemap_xlate
// Combinational address translation. When enabled, the table entry replaces
// the page bits. When disabled, the page bits are zero-extended in place.
// Assumes USE_W >= IDX_W.
module pagemap_xlate #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned USE_W  = 12,
    localparam int unsigned OFF_W = ADDR_W - IDX_W,
    localparam int unsigned PA_W  = OFF_W + USE_W
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [USE_W-1:0]  entry,
    output logic [PA_W-1:0]   paddr
);
    logic [USE_W-1:0] ident_hi;

    // Build the identity-mode upper field, padding only when it is wider.
    generate
        if (USE_W > IDX_W) begin : g_pad
            assign ident_hi = {{(USE_W - IDX_W){1'b0}}, vaddr[ADDR_W-1:OFF_W]};
        end else begin : g_nopad
            assign ident_hi = vaddr[ADDR_W-1:OFF_W];
        end
    endgenerate

    // Pick the upper field and append the untouched page offset.
    always_comb begin
        paddr = {(en ? entry : ident_hi), vaddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/pagemap_top.sv
// Module: pagemap_top
// Paged address mapper top. It ties together the page table, the control
// register and the translator. The entry width is trimmed from the data bus
// to USE_W bits; the upper bus bits are dropped.
// Assumes IDX_W <= USE_W <= BUS_W.
module pagemap_top #(
    parameter int unsigned ADDR_W = pagemap_pkg::PM_ADDR_W,
    parameter int unsigned IDX_W  = pagemap_pkg::PM_IDX_W,
    parameter int unsigned BUS_W  = pagemap_pkg::PM_BUS_W,
    parameter int unsigned USE_W  = pagemap_pkg::PM_USE_W,
    localparam int unsigned OFF_W = ADDR_W - IDX_W,
    localparam int unsigned PA_W  = OFF_W + USE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BUS_W-1:0]  reg_wdata,
    input  logic              tbl_wr,
    input  logic              ctl_wr,
    output logic [PA_W-1:0]   phys_addr
);
    logic             map_en;
    logic [USE_W-1:0] sel_entry;

    pagemap_table #(.IDX_W(IDX_W), .USE_W(USE_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_wr),
        .widx  (reg_idx),
        .wdata (reg_wdata[USE_W-1:0]),
        .ridx  (cpu_addr[ADDR_W-1:OFF_W]),
        .rdata (sel_entry)
    );

    pagemap_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_wr),
        .wbit  (reg_wdata[0]),
        .en    (map_en)
    );

    pagemap_xlate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .USE_W(USE_W)) u_xlate (
        .en    (map_en),
        .vaddr (cpu_addr),
        .entry (sel_entry),
        .paddr (phys_addr)
    );

    // The page offset always passes through untouched.
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

    // In identity mode the physical address is the zero-extended input.
    assert_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !map_en |-> (phys_addr == PA_W'(cpu_addr)));

    // A table write alone never changes the enable.
    assert_tbl_keeps_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && !ctl_wr) |=> (map_en == $past(map_en)));
endmodule

// File: tb/sim_pagemap_top.sv
// Directed bench for pagemap_top: a full-width instance (u0) and a
// narrow-entry instance (u1) share all inputs.
module sim_pagemap_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [3:0]  reg_idx;
    logic [11:0] reg_wdata;
    logic        tbl_wr;
    logic        ctl_wr;
    logic [23:0] phys_w;
    logic [19:0] phys_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] m_tbl [16];
    logic        m_en;

    always #4 clk = ~clk;

    pagemap_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .tbl_wr(tbl_wr), .ctl_wr(ctl_wr), .phys_addr(phys_w)
    );

    pagemap_top #(.USE_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .tbl_wr(tbl_wr), .ctl_wr(ctl_wr), .phys_addr(phys_n)
    );

    function automatic logic [23:0] exp_wide(input logic [15:0] a);
        return m_en ? {m_tbl[a[15:12]], a[11:0]} : {8'h00, a};
    endfunction

    function automatic logic [19:0] exp_narrow(input logic [15:0] a);
        return m_en ? {m_tbl[a[15:12]][7:0], a[11:0]} : {4'h0, a};
    endfunction

    // Compare both instances against the model for the present address.
    task automatic check(input string rq);
        checks++;
        if (phys_w !== exp_wide(cpu_addr)) begin
            errors++;
            $display("FAIL %s wide addr=%h actual=%h expected=%h", rq, cpu_addr, phys_w, exp_wide(cpu_addr));
        end
        checks++;
        if (phys_n !== exp_narrow(cpu_addr)) begin
            errors++;
            $display("FAIL %s narrow addr=%h actual=%h expected=%h", rq, cpu_addr, phys_n, exp_narrow(cpu_addr));
        end
    endtask

    task automatic look(input logic [15:0] a, input string rq);
        cpu_addr = a;
        #1;
        check(rq);
    endtask

    task automatic wr_table(input logic [3:0] idx, input logic [11:0] d);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; tbl_wr = 1'b1;
        @(negedge clk);
        tbl_wr = 1'b0;
        m_tbl[idx] = d;
    endtask

    task automatic wr_ctrl(input logic [11:0] d);
        @(negedge clk);
        reg_wdata = d; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        m_en = d[0];
    endtask

    // R1: a control write held during reset is lost; identity after reset.
    task automatic t_reset();
        rst_n = 1'b0; ctl_wr = 1'b1; reg_wdata = 12'h001;
        repeat (3) @(negedge clk);
        ctl_wr = 1'b0; rst_n = 1'b1; m_en = 1'b0;
        @(negedge clk);
        look(16'hA5C3, "R1");
    endtask

    // R2 and R8: identity map, address changes seen with no clock edge.
    task automatic t_identity();
        @(negedge clk);
        look(16'h0000, "R2");
        look(16'hFFFF, "R2");
        look(16'h7123, "R8");
        look(16'h8ABC, "R8");
    endtask

    // R4 and R5: program every entry; the enable stays off.
    task automatic t_program();
        for (int i = 0; i < 16; i++) begin
            wr_table(4'(i), 12'((i * 12'h0F3) ^ 12'hA50));
        end
        look(16'hC321, "R5");
    endtask

    // R6 then R3: bit 0 clear keeps mapping off, then enable and walk pages.
    task automatic t_enable();
        wr_ctrl(12'hFFE);
        look(16'h3456, "R6");
        wr_ctrl(12'h001);
        for (int i = 0; i < 16; i++) begin
            look({4'(i), 12'(i * 12'h111 + 12'h00F)}, "R3");
        end
    endtask

    // R5: toggling the enable leaves the table contents intact.
    task automatic t_ctrl_keeps_table();
        wr_ctrl(12'h0FE);
        look(16'h9001, "R6");
        wr_ctrl(12'h801);
        look(16'h9001, "R5");
        look(16'h2FFF, "R5");
    endtask

    // R4 and R9: the new entry appears only after the edge, on its page only.
    task automatic t_rewrite();
        @(negedge clk);
        cpu_addr = 16'h5ABC; reg_idx = 4'd5; reg_wdata = 12'h7E1; tbl_wr = 1'b1;
        #1;
        check("R4");
        @(negedge clk);
        tbl_wr = 1'b0; m_tbl[5] = 12'h7E1;
        #1;
        check("R4");
        look(16'h4ABC, "R9");
        look(16'h6ABC, "R9");
    endtask

    // R7: upper data bits are dropped by the narrow instance.
    task automatic t_narrow();
        wr_table(4'd2, 12'hF3C);
        look(16'h2468, "R7");
        wr_table(4'd2, 12'h0C3);
        look(16'h2000, "R7");
    endtask

    initial begin
        cpu_addr = '0; reg_idx = '0; reg_wdata = '0; tbl_wr = 1'b0; ctl_wr = 1'b0; rst_n = 1'b0;
        m_en = 1'b0;
        for (int i = 0; i < 16; i++) m_tbl[i] = '0;
        t_reset();
        t_identity();
        t_program();
        t_enable();
        t_ctrl_keeps_table();
        t_rewrite();
        t_narrow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule